// File: doc/BRIEF.md
# Ethernet Transmit Deferral Timer

This block gates the start of each frame on a half-duplex Ethernet link. After the medium has been busy, a transmitter must hold off for an inter-frame gap before it drives the line again. The timer watches a carrier-sense input and a frame-ready request. It counts transmit clock cycles under the deferral rule that is selected. It then raises a transmit-permit level that stays high until the request is withdrawn.

Two rules are available. The single rule waits for a quiet medium and then counts a programmed gap reduced by a fixed offset of three cycles. The two-part rule splits the gap. During the first part, any carrier activity restarts the wait. Once the second part begins, it runs to completion whatever the medium does. The first part is usually programmed to about two thirds of the gap and the second part to the remaining third, and together they should be no shorter than the minimum gap. In full-duplex operation no deferral is applied.

Top module: `tx_defer_timer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `tx_permit_o` is low and the timer is idle.
- R2: When `full_duplex_i` is 1 on the edge at which an idle timer first samples `frame_rdy_i` high, `tx_permit_o` is high after that same edge, with no deferral.
- R3: In single mode (`two_part_i` = 0), `tx_permit_o` rises on the edge where `carrier_i` has been sampled low on L+1 consecutive edges after the request was taken, with L = `gap_len_i` - 3. The first quiet sample marks the medium as silent, and L counted cycles follow it.
- R4: In single mode, a `gap_len_i` of 0, 1, 2 or 3 gives L = 0: the offset saturates and does not wrap.
- R5: In two-part mode (`two_part_i` = 1), part 1 ends on the edge where `carrier_i` has been sampled low on `part1_len_i`+1 consecutive edges. `tx_permit_o` then rises `part2_len_i` edges later, or on that same edge when `part2_len_i` is 0.
- R6: A `carrier_i` sample of 1 at any edge of part 1, or of the single-mode wait, clears the count. The wait restarts from the next quiet sample.
- R7: `carrier_i` during part 2 is ignored. Part 2 completes on schedule and permit follows.
- R8: `tx_permit_o` stays high while `frame_rdy_i` stays high. It falls after the first edge that samples `frame_rdy_i` low, and the timer returns to idle. The next request runs a full new deferral.
- R9: If `frame_rdy_i` falls before the deferral completes, the sequence is abandoned and `tx_permit_o` stays low.
- R10: The mode and lengths are captured on the edge that accepts a request. Changing `two_part_i`, `full_duplex_i`, `gap_len_i`, `part1_len_i` or `part2_len_i` after that edge does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_i | input | 1 | Carrier sense, 1 = medium busy |
| frame_rdy_i | input | 1 | A frame is waiting to be sent |
| two_part_i | input | 1 | 1 = two-part deferral, 0 = single deferral |
| full_duplex_i | input | 1 | 1 = full duplex, deferral skipped |
| gap_len_i | input | LEN_W | Single-mode gap length in cycles (offset of 3 applied) |
| part1_len_i | input | LEN_W | Two-part mode, first-part length |
| part2_len_i | input | LEN_W | Two-part mode, second-part length |
| tx_permit_o | output | 1 | Registered transmit-permit level |

## Verification
The bench builds the timer with LEN_W = 4, so every length is a value from 0 to 15. At that width the bench can sweep every gap value in single mode, including all four saturating values, and every pair of part-1 and part-2 lengths in two-part mode. Expected permit latencies are computed arithmetically from the busy span and the lengths. Carrier glitches are placed at chosen edges, such as the first and last edge of part 1 and the first and last edge of part 2, which tests the restart and ignore rules at their boundaries. Configuration changes during a count are also applied and must have no effect.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PH1  = 2'd1,
    S_PH2  = 2'd2,
    S_GO   = 2'd3
  } txd_state_e;
endpackage

// File: rtl/txd_cfg_capture.sv
module txd_cfg_capture #(
  parameter int LEN_W      = 8,
  parameter int GAP_OFFSET = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             two_part_i,
  input  logic [LEN_W-1:0] gap_len_i,
  input  logic [LEN_W-1:0] part1_len_i,
  input  logic [LEN_W-1:0] part2_len_i,
  output logic [LEN_W-1:0] len1_o,
  output logic [LEN_W-1:0] len2_o
);
  localparam logic [LEN_W-1:0] OFS = LEN_W'(GAP_OFFSET);

  logic [LEN_W-1:0] gap_eff;
  logic [LEN_W-1:0] len1_d;
  logic [LEN_W-1:0] len2_d;

  // saturating subtract of the fixed offset
  always_comb begin
    gap_eff = (gap_len_i > OFS) ? (gap_len_i - OFS) : '0;
    len1_d  = two_part_i ? part1_len_i : gap_eff;
    len2_d  = two_part_i ? part2_len_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len1_o <= '0;
      len2_o <= '0;
    end else if (load_i) begin
      len1_o <= len1_d;
      len2_o <= len2_d;
    end
  end

  p_gap_saturate_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && !two_part_i && (gap_len_i <= OFS)) |=> (len1_o == '0));

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(len1_o) && $stable(len2_o)));
endmodule

// File: rtl/txd_cycle_counter.sv
module txd_cycle_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [LEN_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_o <= '0;
    else if (inc_i)     cnt_o <= cnt_o + 1'b1;
  end

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clear_i) |-> (cnt_o != '1));
endmodule

// File: rtl/txd_sequencer.sv
module txd_sequencer
  import txd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdy_i,
  input  logic             carrier_i,
  input  logic             full_duplex_i,
  input  logic [LEN_W-1:0] len1_i,
  input  logic [LEN_W-1:0] len2_i,
  input  logic [LEN_W-1:0] cnt_i,
  output logic             load_o,
  output logic             clr_o,
  output logic             inc_o,
  output logic             permit_o
);
  txd_state_e st, nxt;
  logic [LEN_W:0] cnt_plus;

  assign cnt_plus = {1'b0, cnt_i} + 1'b1;

  always_comb begin
    nxt    = st;
    load_o = 1'b0;
    clr_o  = 1'b0;
    inc_o  = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (rdy_i) begin
          load_o = 1'b1;
          clr_o  = 1'b1;
          nxt    = full_duplex_i ? S_GO : S_PH1;
        end
      end
      S_PH1: begin
        if (!rdy_i) begin
          clr_o = 1'b1;
          nxt   = S_IDLE;
        end else if (carrier_i) begin
          clr_o = 1'b1;
        end else if (cnt_i == len1_i) begin
          clr_o = 1'b1;
          nxt   = (len2_i == '0) ? S_GO : S_PH2;
        end else begin
          inc_o = 1'b1;
        end
      end
      S_PH2: begin
        if (!rdy_i) begin
          clr_o = 1'b1;
          nxt   = S_IDLE;
        end else if (cnt_plus == {1'b0, len2_i}) begin
          clr_o = 1'b1;
          nxt   = S_GO;
        end else begin
          inc_o = 1'b1;
        end
      end
      S_GO: begin
        if (!rdy_i) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      permit_o <= 1'b0;
    end else begin
      st       <= nxt;
      permit_o <= (nxt == S_GO);
    end
  end

  p_permit_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    permit_o |-> $past(rdy_i));

  p_withdraw_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    !rdy_i |=> !permit_o);

  p_fd_immediate_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && rdy_i && full_duplex_i) |=> permit_o);

  p_carrier_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_PH1 && rdy_i && carrier_i) |=> (st == S_PH1 && cnt_i == '0));

  p_part2_runs_on_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_PH2 && rdy_i) |=> (st == S_PH2 || st == S_GO));

  p_ph1_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_PH1) |-> (cnt_i <= len1_i));
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int LEN_W      = 8,
  parameter int GAP_OFFSET = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             carrier_i,
  input  logic             frame_rdy_i,
  input  logic             two_part_i,
  input  logic             full_duplex_i,
  input  logic [LEN_W-1:0] gap_len_i,
  input  logic [LEN_W-1:0] part1_len_i,
  input  logic [LEN_W-1:0] part2_len_i,
  output logic             tx_permit_o
);
  logic [LEN_W-1:0] len1, len2, cnt;
  logic load, clr, inc;

  txd_cfg_capture #(.LEN_W(LEN_W), .GAP_OFFSET(GAP_OFFSET)) u_cfg (
    .clk(clk), .rst(rst), .load_i(load), .two_part_i(two_part_i),
    .gap_len_i(gap_len_i), .part1_len_i(part1_len_i), .part2_len_i(part2_len_i),
    .len1_o(len1), .len2_o(len2)
  );

  txd_cycle_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(clr), .inc_i(inc), .cnt_o(cnt)
  );

  txd_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .rdy_i(frame_rdy_i), .carrier_i(carrier_i),
    .full_duplex_i(full_duplex_i), .len1_i(len1), .len2_i(len2), .cnt_i(cnt),
    .load_o(load), .clr_o(clr), .inc_o(inc), .permit_o(tx_permit_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !tx_permit_o);
endmodule

// File: tb/sim_tx_defer_timer.sv
module sim_tx_defer_timer;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrier = 1'b0, rdy = 1'b0, tp = 1'b0, fd = 1'b0;
  logic [W-1:0] gap = '0, p1 = '0, p2 = '0;
  logic permit;

  int vectors = 0, misses = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_defer_timer #(.LEN_W(W)) u0 (
    .clk(clk), .rst(rst), .carrier_i(carrier), .frame_rdy_i(rdy),
    .two_part_i(tp), .full_duplex_i(fd), .gap_len_i(gap),
    .part1_len_i(p1), .part2_len_i(p2), .tx_permit_o(permit)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit busy_at(int k, int b, int g);
    return (k >= 1 && k <= b) || (g > 0 && k == g);
  endfunction

  // One request: carrier busy on edges 1..b, optional one-edge glitch at g.
  task automatic run(input bit f, input bit two, input int n, input int a,
                     input int c, input int b, input int g, input bit chg,
                     input string req);
    int q, len, exp, first;
    q   = b + 1;
    len = two ? a : ((n > 3) ? n - 3 : 0);
    if (g > 0 && g >= q && g <= q + len) q = g + 1;
    exp = f ? 0 : q + len + (two ? c : 0);
    @(negedge clk);
    fd = f; tp = two; gap = W'(n); p1 = W'(a); p2 = W'(c);
    carrier = 1'b0; rdy = 1'b1;
    first = -1;
    for (int k = 0; k < 100 && first < 0; k++) begin
      @(negedge clk);
      if (permit) first = k;
      else begin
        if (chg && k == 0) begin
          fd = 1'b1; tp = ~two; gap = ~W'(n); p1 = ~W'(a); p2 = ~W'(c);
        end
        carrier = busy_at(k + 1, b, g);
      end
    end
    check(first == exp, req, first, exp);
    carrier = 1'b0;
    @(negedge clk);
    check(permit == 1'b1, "R8 hold", int'(permit), 1);
    rdy = 1'b0;
    @(negedge clk);
    check(permit == 1'b0, "R8 drop", int'(permit), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(permit == 1'b0, "R1", int'(permit), 0);
    rst = 1'b0;
    @(negedge clk);
    check(permit == 1'b0, "R1", int'(permit), 0);

    // R2: full duplex, any mode and length
    for (int n = 0; n < 16; n++) run(1'b1, n[0], n, n, 15 - n, 2, 0, 1'b0, "R2");

    // R3 / R4: single mode, every gap value, two busy spans
    for (int n = 0; n < 16; n++) begin
      run(1'b0, 1'b0, n, 7, 7, 0, 0, 1'b0, (n <= 3) ? "R4" : "R3");
      run(1'b0, 1'b0, n, 2, 9, 3, 0, 1'b0, (n <= 3) ? "R4" : "R3");
    end

    // R5: two-part mode, every pair of lengths
    for (int a = 0; a < 16; a++)
      for (int c = 0; c < 16; c++) run(1'b0, 1'b1, 5, a, c, 1, 0, 1'b0, "R5");

    // R6: carrier in part 1 at first, middle and last edge
    for (int a = 1; a < 16; a++) begin
      run(1'b0, 1'b1, 0, a, 3, 1, 2, 1'b0, "R6");
      run(1'b0, 1'b1, 0, a, 3, 1, 2 + a / 2, 1'b0, "R6");
      run(1'b0, 1'b1, 0, a, 2, 1, 2 + a, 1'b0, "R6");
    end
    run(1'b0, 1'b0, 10, 0, 0, 0, 8, 1'b0, "R6");
    run(1'b0, 1'b0, 10, 0, 0, 2, 3, 1'b0, "R6");

    // R7: carrier in part 2 at first and last edge
    for (int c = 1; c < 16; c++) begin
      run(1'b0, 1'b1, 0, 4, c, 0, 6, 1'b0, "R7");
      run(1'b0, 1'b1, 0, 4, c, 0, 5 + c, 1'b0, "R7");
    end

    // R10: configuration changes after the request is taken
    for (int a = 0; a < 16; a += 3) begin
      run(1'b0, 1'b1, 9, a, 15 - a, 2, 0, 1'b1, "R10");
      run(1'b0, 1'b0, a, 3, 3, 1, 0, 1'b1, "R10");
    end

    // R9: request withdrawn mid-deferral
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      fd = 1'b0; tp = 1'b1; p1 = 4'd6; p2 = 4'd6; carrier = 1'b1; rdy = 1'b1;
      repeat (5) @(negedge clk);
      carrier = 1'b0;
      repeat (4) @(negedge clk);
      rdy = 1'b0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (permit) seen++;
      end
      check(seen == 0, "R9", seen, 0);
    end
    run(1'b0, 1'b1, 0, 3, 3, 0, 0, 1'b0, "R9 then R8 fresh");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule